// File: doc/BRIEF.md
# Duty-Sample FIFO Pulse-Width Modulator

This block produces one pulse-width modulated output from a free-running period counter. Each clock the counter is checked for exact equality with an active duty register. The output is high from the start of every period, and it drops only on the cycle in which the count equals the duty value. Software-style write strobes feed duty samples into a short queue and set the period length. A status output reports how many queued samples are waiting.

A new duty value normally lands in the running period at once. Only one sample may be applied per period in this way. Later samples wait in the queue and move into the duty register one per period, at the counter's rollover. Because of the equality compare, lowering the duty below a count the period has already passed removes that period's falling edge, so the whole period is high. A configuration input selects a deferred policy. Under it, such a late, lowered value waits for the next period boundary instead.

Top module: `pwm_duty_fifo`

## Requirements
- R1: With period value P written through the period strobe, the count runs 0 to P-1 and wraps, so the output pattern repeats every P cycles.
- R2: With duty d (0 < d < P) the output is high for counts 0 to d-1 and low from count d to the end of the period. A duty of P or more keeps it high for the whole period.
- R3: A duty of 0 keeps the output low for the whole period.
- R4: After reset the output is low, the queue is empty and the overflow flag is clear. While the enable is low the output is low and the count is held at 0, so a later enable starts a fresh period.
- R5: A sample written while the queue is empty, and with no sample loaded since the last rollover, becomes the active duty on the next cycle and acts within the running period. For example, raising the duty mid-period lengthens that period's high phase.
- R6: In immediate mode, lowering the duty to a value the running count has already passed gives a period that is high throughout. The new value shapes the following period.
- R7: In deferred mode (defer_mode = 1), a sample no greater than the current count is queued rather than applied, so the old duty shapes the running period. The sample then takes over at the next rollover.
- R8: Samples that are not applied at once are queued and loaded one per rollover in write order. fill_level reports the number of queued samples.
- R9: The queue holds 4 samples, and three back-to-back writes into an empty queue never overflow. A write while it is full is dropped and sets ovf_flag. ovf_flag stays set until an ovf_clr pulse.
- R10: At a rollover with an empty queue the active duty is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the count at 0 and the output low |
| defer_mode | input | 1 | 1 = defer late lowered samples to the next period |
| period_we | input | 1 | Period write strobe |
| period_wdata | input | CW | Period length in clocks |
| sample_we | input | 1 | Duty sample write strobe |
| sample_wdata | input | CW | Duty sample value |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| pwm_out | output | 1 | Modulated output, high = active |
| fill_level | output | clog2(DEPTH+1) | Number of queued samples |
| ovf_flag | output | 1 | Sticky queue overflow flag |

## Verification
Some properties are checked on every cycle by the assertions:
- The count returns to 0 after a rollover or while disabled.
- The queue level stays within its depth, and the queue never takes a push when full or a pop when empty.
- A write into a full queue always raises the overflow flag.
- A zero duty never drives the output high.
- The duty register holds when the queue is empty and nothing is written.

Only the scenarios can show the waveform shapes: the exact high-phase lengths, the full-period high after a late lowered duty, the deferred policy keeping the old edge, and the in-order draining of queued samples one per period.

// File: rtl/pwm_fifo_pkg.sv
// Shared types and width helpers for the duty-sample FIFO PWM.
// Assumes: depths are at least 1.
package pwm_fifo_pkg;

    typedef enum logic {
        MODE_IMMEDIATE = 1'b0,
        MODE_DEFER     = 1'b1
    } duty_mode_e;

    // Width of a queue pointer for a given depth.
    function automatic int ptr_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of a fill counter able to hold 0..depth.
    function automatic int fill_w(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/pwm_period_counter.sv
// Period counter: holds the period length and counts 0..period-1.
// wrap marks the last count of a period (the cycle before the count returns to 0).
// Assumes: a period of 0 behaves as a period of 1.
module pwm_period_counter #(
    parameter int CW = 8,
    parameter logic [CW-1:0] PERIOD_RST = CW'(100)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          period_we,
    input  logic [CW-1:0] period_wdata,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    logic [CW-1:0] period_q;
    logic [CW:0]   cnt_plus;

    // Period length register, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          period_q <= PERIOD_RST;
        else if (period_we)  period_q <= period_wdata;
    end

    // Rollover detection: next count would reach the period length.
    always_comb begin
        cnt_plus = {1'b0, cnt} + (CW+1)'(1);
        wrap     = en && (cnt_plus >= {1'b0, period_q});
    end

    // Counter: held at 0 while disabled, cleared at rollover.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (!en)   cnt <= '0;
        else if (wrap)  cnt <= '0;
        else            cnt <= cnt + CW'(1);
    end

    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

endmodule

// File: rtl/pwm_sample_fifo.sv
// Duty sample queue: circular buffer with a level count.
// Assumes: the caller never pushes when full nor pops when empty.
module pwm_sample_fifo
    import pwm_fifo_pkg::*;
#(
    parameter int CW    = 8,
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [CW-1:0]             din,
    input  logic                      pop,
    output logic [CW-1:0]             head,
    output logic [fill_w(DEPTH)-1:0]  level
);
    localparam int AW = ptr_w(DEPTH);
    localparam int FW = fill_w(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [CW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // Sample storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Write pointer advance with wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (push)  wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + AW'(1);
    end

    // Read pointer advance with wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_ptr <= '0;
        else if (pop)   rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + AW'(1);
    end

    // Level count tracking pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else begin
            case ({push, pop})
                2'b10:   level <= level + FW'(1);
                2'b01:   level <= level - FW'(1);
                default: level <= level;
            endcase
        end
    end

    assign head = mem[rd_ptr];

    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FW'(DEPTH));
    a_r9_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level < FW'(DEPTH)));
    a_r8_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level != '0));

endmodule

// File: rtl/pwm_edge_gen.sv
// Output stage: the output is high from period start until the count equals the duty.
// Assumes: wrap is high on the last count of each period.
module pwm_edge_gen #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] duty,
    output logic          pwm_out
);
    logic act_q;

    // Active-phase flag: re-armed at each period start, dropped on equality.
    always_ff @(posedge clk) begin
        if (!rst_n)               act_q <= 1'b1;
        else if (!en || wrap)     act_q <= 1'b1;
        else if (cnt == duty)     act_q <= 1'b0;
    end

    // Output: active phase, not yet at the equality point, and enabled.
    assign pwm_out = en && act_q && (cnt != duty);

    a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |-> !pwm_out);

endmodule

// File: rtl/pwm_duty_fifo.sv
// Top: duty-sample FIFO PWM. A sample applies at once if the queue is empty and no
// sample was loaded since the last rollover; otherwise it is queued and loaded at a
// rollover. Deferred mode queues samples that the running count has already passed.
// Assumes: single clock domain, strobes are one cycle per write.
module pwm_duty_fifo
    import pwm_fifo_pkg::*;
#(
    parameter int CW    = 8,
    parameter int DEPTH = 4,
    parameter logic [CW-1:0] PERIOD_RST = CW'(100)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      defer_mode,
    input  logic                      period_we,
    input  logic [CW-1:0]             period_wdata,
    input  logic                      sample_we,
    input  logic [CW-1:0]             sample_wdata,
    input  logic                      ovf_clr,
    output logic                      pwm_out,
    output logic [fill_w(DEPTH)-1:0]  fill_level,
    output logic                      ovf_flag
);
    localparam int FW = fill_w(DEPTH);

    logic [CW-1:0] cnt, duty_q, head;
    logic          wrap, empty, full, late_low, bypass, push, pop, used_q;
    duty_mode_e    mode;

    pwm_period_counter #(.CW(CW), .PERIOD_RST(PERIOD_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en),
        .period_we(period_we), .period_wdata(period_wdata),
        .cnt(cnt), .wrap(wrap)
    );

    pwm_sample_fifo #(.CW(CW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din(sample_wdata), .pop(pop),
        .head(head), .level(fill_level)
    );

    pwm_edge_gen #(.CW(CW)) u_edge (
        .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap),
        .cnt(cnt), .duty(duty_q), .pwm_out(pwm_out)
    );

    // Write routing: direct apply, queue, or drop.
    always_comb begin
        mode     = duty_mode_e'(defer_mode);
        empty    = (fill_level == '0);
        full     = (fill_level == FW'(DEPTH));
        late_low = (mode == MODE_DEFER) && en && !wrap && (sample_wdata <= cnt);
        bypass   = sample_we && empty && !used_q && !late_low;
        push     = sample_we && !full && !bypass;
        pop      = wrap && !empty;
    end

    // Active duty register: rollover pop or direct apply.
    always_ff @(posedge clk) begin
        if (!rst_n)       duty_q <= '0;
        else if (pop)     duty_q <= head;
        else if (bypass)  duty_q <= sample_wdata;
    end

    // Load-slot flag: one load per period; freed at a rollover with nothing to pop.
    always_ff @(posedge clk) begin
        if (!rst_n)              used_q <= 1'b0;
        else if (pop || bypass)  used_q <= 1'b1;
        else if (wrap)           used_q <= 1'b0;
    end

    // Sticky overflow flag; a new overflow wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ovf_flag <= 1'b0;
        else if (sample_we && full)   ovf_flag <= 1'b1;
        else if (ovf_clr)             ovf_flag <= 1'b0;
    end

    a_r9_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_we && full) |=> ovf_flag);
    a_r10_duty_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_we && empty) |=> $stable(duty_q));
    a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_out);

endmodule

// File: tb/tb_pwm_duty_fifo.sv
module tb_pwm_duty_fifo;
    localparam int CW    = 8;
    localparam int DEPTH = 4;
    localparam int FW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n, en, defer_mode, period_we, sample_we, ovf_clr;
    logic [CW-1:0] period_wdata, sample_wdata;
    logic          pwm_out, ovf_flag;
    logic [FW-1:0] fill_level;

    int n_chk = 0;
    int n_fail = 0;
    int P = 10;

    always #5 clk = ~clk;

    pwm_duty_fifo #(.CW(CW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .defer_mode(defer_mode),
        .period_we(period_we), .period_wdata(period_wdata),
        .sample_we(sample_we), .sample_wdata(sample_wdata),
        .ovf_clr(ovf_clr), .pwm_out(pwm_out),
        .fill_level(fill_level), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_sample(input int v);
        sample_we = 1'b1; sample_wdata = CW'(v);
        @(negedge clk);
        sample_we = 1'b0;
    endtask

    task automatic wr_period(input int v);
        period_we = 1'b1; period_wdata = CW'(v);
        @(negedge clk);
        period_we = 1'b0;
        P = v;
    endtask

    // Count high cycles over one period, starting at a count-0 cycle.
    task automatic measure(output int hi);
        hi = 0;
        for (int i = 0; i < P; i++) begin
            #1;
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    // One period with a sample written during count `at`.
    task automatic run_with_write(input int at, input int val,
                                  output int hi, output int fill_after);
        hi = 0; fill_after = -1;
        for (int i = 0; i < P; i++) begin
            sample_we = (i == at);
            if (i == at) sample_wdata = CW'(val);
            #1;
            if (pwm_out) hi++;
            if (i == at + 1) fill_after = int'(fill_level);
            @(negedge clk);
        end
        sample_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0; defer_mode = 1'b0; period_we = 1'b0;
        sample_we = 1'b0; ovf_clr = 1'b0; period_wdata = '0; sample_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R4 reset output", int'(pwm_out), 0);
        chk("R4 reset fill", int'(fill_level), 0);
        chk("R4 reset overflow", int'(ovf_flag), 0);
    endtask

    task automatic t_basic();
        int hi;
        @(negedge clk);
        wr_period(10);
        wr_sample(4);
        en = 1'b1;
        measure(hi); chk("R2 duty 4 high cycles", hi, 4);
        measure(hi); chk("R10 duty kept next period", hi, 4);
        en = 1'b0; #1;
        chk("R4 output low when disabled", int'(pwm_out), 0);
        @(negedge clk);
        wr_sample(0);
        en = 1'b1;
        measure(hi); chk("R3 zero duty", hi, 0);
        en = 1'b0; @(negedge clk);
        wr_sample(12);
        en = 1'b1;
        measure(hi); chk("R2 duty above period", hi, 10);
        en = 1'b0; @(negedge clk);
    endtask

    task automatic t_midperiod();
        int hi, fa;
        wr_sample(6);
        en = 1'b1;
        measure(hi); chk("R2 duty 6", hi, 6);
        run_with_write(4, 3, hi, fa);
        chk("R6 late lowered duty full period", hi, 10);
        chk("R6 no queue use", fa, 0);
        measure(hi); chk("R6 new duty next period", hi, 3);
        run_with_write(2, 7, hi, fa);
        chk("R5 raised duty in running period", hi, 7);
        defer_mode = 1'b1;
        run_with_write(4, 2, hi, fa);
        chk("R7 deferred keeps old edge", hi, 7);
        chk("R7 deferred sample queued", fa, 1);
        #1; chk("R7 queue drained at rollover", int'(fill_level), 0);
        measure(hi); chk("R7 deferred value next period", hi, 2);
        run_with_write(1, 5, hi, fa);
        chk("R5 deferred mode raise applies at once", hi, 5);
        defer_mode = 1'b0;
        en = 1'b0; @(negedge clk);
    endtask

    task automatic t_queue();
        int hi;
        int exp_hi[6] = '{2, 5, 7, 1, 4, 4};
        int exp_fill[6] = '{4, 3, 2, 1, 0, 0};
        wr_sample(2); wr_sample(5); wr_sample(7);
        #1; chk("R9 three writes no overflow", int'(ovf_flag), 0);
        @(negedge clk);
        wr_sample(1); wr_sample(4);
        #1; chk("R8 fill level full", int'(fill_level), 4);
        chk("R9 no overflow at exact fill", int'(ovf_flag), 0);
        @(negedge clk);
        wr_sample(9);
        #1; chk("R9 overflow flag set", int'(ovf_flag), 1);
        chk("R9 dropped write leaves level", int'(fill_level), 4);
        @(negedge clk);
        repeat (2) @(negedge clk);
        #1; chk("R9 overflow flag sticky", int'(ovf_flag), 1);
        @(negedge clk);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        #1; chk("R9 overflow cleared", int'(ovf_flag), 0);
        @(negedge clk);
        en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #1; chk("R8 fill at period start", int'(fill_level), exp_fill[k]);
            measure(hi);
            chk((k == 5) ? "R10 empty queue keeps duty" : "R8 queued order", hi, exp_hi[k]);
        end
        en = 1'b0; @(negedge clk);
    endtask

    task automatic t_period();
        int hi, bad;
        wr_period(5);
        wr_sample(2);
        en = 1'b1;
        bad = 0;
        for (int i = 0; i < 15; i++) begin
            #1;
            if (int'(pwm_out) != (((i % 5) < 2) ? 1 : 0)) bad++;
            @(negedge clk);
        end
        chk("R1 period 5 pattern mismatches", bad, 0);
        @(negedge clk);
        en = 1'b0; #1;
        chk("R4 mid-period disable output", int'(pwm_out), 0);
        @(negedge clk);
        en = 1'b1;
        measure(hi); chk("R4 fresh period after enable", hi, 2);
        en = 1'b0; @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_midperiod();
        t_queue();
        t_period();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule